// File: doc/BRIEF.md
# Four-CPU Snooping MESI Coherence Controller

This block keeps four single-line, direct-mapped CPU caches coherent over one shared snoop bus. Each CPU port can issue a plain load, a store, a load that announces an upcoming store, or an atomic increment. The controller takes one request at a time and carries it out as a single bus transaction. In that transaction it moves the line states of the requester and all its peers, takes the fill data either from the backing memory or from a peer that holds the line Modified, and writes a dirty victim back when a line is replaced.

For every address the controller also keeps a flag that says whether the backing memory copy is current. A store clears the flag. A writeback, whether from a replaced line or from a peer that was forced to flush, sets it again. The line states, tags and memory flags are brought out on ports so that the system around the block can see them.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line state is Invalid and every bit of mem_valid_o is 1 (bit k belongs to address k). The backing memory holds 0. Line states use two bits per CPU, with CPU i at bits 2i+1:2i, coded Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R2: A load (op code 0) that misses installs the line as Shared with the memory data. Peers that hold it Exclusive drop to Shared, and the address's memory flag does not change. A load hit returns the line data and changes no state.
- R3: A request to an address other than the resident one replaces the line. A clean victim is dropped with no memory write and no change to any flag.
- R4: A load with intent to store (op code 2) invalidates every peer copy of the address. The requester becomes Exclusive and the flag stays as it was. If a peer held the line Modified, the requester takes that peer's data and becomes Modified instead.
- R5: A store (op code 1) to an Exclusive or Shared line invalidates the peer copies. The line becomes Modified and holds the store data, and the address's memory flag clears.
- R6: An atomic increment (op code 3) whose address a peer holds Modified takes the data from that peer, which goes Invalid. The requester ends Modified with the value plus one, and the memory flag stays 0.
- R7: Replacing a Modified line writes its data back to the victim address and sets that address's flag.
- R8: A load that snoops a Modified peer makes that peer write back and drop to Shared. The requester gets the line as Shared with the peer's data, and the flag becomes 1.
- R9: A store or increment to a line the requester does not hold runs as a read-invalidate followed by the write. The line ends Modified.
- R10: Only one transaction runs at a time. Requests raised together are served lowest CPU index first. Each completion raises a single-cycle pulse on the requester's done_o bit.
- R11: While done_o is high, rdata_o shows the requester's final line data: the store data for a store, the incremented value for an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | N_CPU | Request pending per CPU, held until done |
| req_op_i | input | 2*N_CPU | Operation code per CPU |
| req_addr_i | input | N_CPU*ADDR_W | Request address per CPU |
| req_wdata_i | input | N_CPU*DATA_W | Store data per CPU |
| done_o | output | N_CPU | One-cycle completion pulse per CPU |
| rdata_o | output | DATA_W | Final line data of the completed request |
| line_state_o | output | 2*N_CPU | Line state per CPU |
| line_tag_o | output | N_CPU*ADDR_W | Resident address per CPU |
| mem_valid_o | output | 2**ADDR_W | Memory-current flag per address |

## Verification
A directed sequence takes one line from memory through several caches: shared reads, a clean eviction, an exclusive grab, a store, an increment served by a peer, and a dirty eviction. Each step tells apart a memory fill from a peer fill and a silent drop from a writeback. After that, stores to Shared lines, forced flushes on loads and writes to lines the requester does not hold cover the remaining transitions. Three requests raised in the same cycle check the grant order. A long run of seeded random operations over four addresses then mixes every kind of conflict, and a bench model predicts all line states, tags, memory flags and returned data for each step.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_e;
  typedef enum logic [1:0] {OP_LD = 2'd0, OP_ST = 2'd1, OP_LDX = 2'd2, OP_INC = 2'd3} op_e;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_EXEC = 2'd1, PH_RESP = 2'd2} phase_e;
endpackage

// File: rtl/mesi_prio_arb.sv
module mesi_prio_arb #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     gnt_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !any_o) begin
        any_o    = 1'b1;
        idx_o    = IDX_W'(i);
        gnt_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mesi_line.sv
module mesi_line
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  mesi_e             state_d_i,
  input  logic [ADDR_W-1:0] tag_d_i,
  input  logic [DATA_W-1:0] data_d_i,
  output mesi_e             state_o,
  output logic [ADDR_W-1:0] tag_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_I;
      tag_o   <= '0;
      data_o  <= '0;
    end else if (we_i) begin
      state_o <= state_d_i;
      tag_o   <= tag_d_i;
      data_o  <= data_d_i;
    end
  end
endmodule

// File: rtl/mesi_mem.sv
module mesi_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  // victim writeback port: always refreshes the flag
  input  logic              vic_en_i,
  input  logic [ADDR_W-1:0] vic_addr_i,
  input  logic [DATA_W-1:0] vic_data_i,
  // request-address port: peer flush data and/or flag update
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_data_we_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              req_flag_we_i,
  input  logic              req_flag_i,
  output logic [DEPTH-1:0]  valid_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[e]   <= '0;
        valid_o[e] <= 1'b1;
      end else begin
        if (vic_en_i && vic_addr_i == ADDR_W'(e)) begin
          mem_q[e]   <= vic_data_i;
          valid_o[e] <= 1'b1;
        end
        if (req_data_we_i && req_addr_i == ADDR_W'(e)) mem_q[e] <= req_data_i;
        if (req_flag_we_i && req_addr_i == ADDR_W'(e)) valid_o[e] <= req_flag_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  assert_port_clash_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vic_en_i && (req_data_we_i || req_flag_we_i)) |-> (vic_addr_i != req_addr_i));
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int N_CPU  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CPU-1:0]           req_valid_i,
  input  logic [2*N_CPU-1:0]         req_op_i,
  input  logic [N_CPU*ADDR_W-1:0]    req_addr_i,
  input  logic [N_CPU*DATA_W-1:0]    req_wdata_i,
  output logic [N_CPU-1:0]           done_o,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [2*N_CPU-1:0]         line_state_o,
  output logic [N_CPU*ADDR_W-1:0]    line_tag_o,
  output logic [(1<<ADDR_W)-1:0]     mem_valid_o
);
  localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1;

  op_e               op_in   [N_CPU];
  logic [ADDR_W-1:0] addr_in [N_CPU];
  logic [DATA_W-1:0] wd_in   [N_CPU];
  mesi_e             st      [N_CPU];
  logic [ADDR_W-1:0] tag     [N_CPU];
  logic [DATA_W-1:0] dat     [N_CPU];
  mesi_e             st_d    [N_CPU];
  logic [DATA_W-1:0] dat_d   [N_CPU];
  logic [ADDR_W-1:0] tag_d   [N_CPU];

  phase_e            phase_q;
  logic [IDX_W-1:0]  cur_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic              arb_any;
  logic [IDX_W-1:0]  arb_idx;
  logic [N_CPU-1:0]  arb_gnt;
  logic              exec;

  assign exec = (phase_q == PH_EXEC);

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    assign op_in[g]   = op_e'(req_op_i[g*2 +: 2]);
    assign addr_in[g] = req_addr_i[g*ADDR_W +: ADDR_W];
    assign wd_in[g]   = req_wdata_i[g*DATA_W +: DATA_W];

    mesi_line #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_line (
      .clk_i, .rst_ni, .we_i(exec),
      .state_d_i(st_d[g]), .tag_d_i(tag_d[g]), .data_d_i(dat_d[g]),
      .state_o(st[g]), .tag_o(tag[g]), .data_o(dat[g])
    );

    assign line_state_o[g*2 +: 2]          = st[g];
    assign line_tag_o[g*ADDR_W +: ADDR_W]  = tag[g];
  end

  mesi_prio_arb #(.N(N_CPU), .IDX_W(IDX_W)) u_arb (
    .req_i(req_valid_i & {N_CPU{phase_q == PH_IDLE}}),
    .any_o(arb_any), .idx_o(arb_idx), .gnt_o(arb_gnt)
  );

  // ---------------- transaction sequencing ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cur_q   <= '0;
      op_q    <= OP_LD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (arb_any) begin
          phase_q <= PH_EXEC;
          cur_q   <= arb_idx;
          op_q    <= op_in[arb_idx];
          addr_q  <= addr_in[arb_idx];
          wdata_q <= wd_in[arb_idx];
        end
        PH_EXEC: phase_q <= PH_RESP;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // ---------------- snoop resolution ----------------
  mesi_e             own_st;
  logic [ADDR_W-1:0] own_tag;
  logic [DATA_W-1:0] own_dat;
  logic              hit, vic_dirty, peer_mod, is_write;
  logic [N_CPU-1:0]  peer_hit;
  logic [DATA_W-1:0] peer_dat, mem_rd, base, new_dat;
  mesi_e             own_nx;

  always_comb begin
    own_st   = st[cur_q];
    own_tag  = tag[cur_q];
    own_dat  = dat[cur_q];
    hit      = (own_st != ST_I) && (own_tag == addr_q);
    vic_dirty = (own_st == ST_M) && !hit;
    peer_mod = 1'b0;
    peer_dat = '0;
    for (int p = 0; p < N_CPU; p++) begin
      peer_hit[p] = (cur_q != IDX_W'(p)) && (st[p] != ST_I) && (tag[p] == addr_q);
      if (peer_hit[p] && st[p] == ST_M) begin
        peer_mod = 1'b1;
        peer_dat = dat[p];
      end
    end
    base     = hit ? own_dat : (peer_mod ? peer_dat : mem_rd);
    is_write = (op_q == OP_ST) || (op_q == OP_INC);
    unique case (op_q)
      OP_ST:   new_dat = wdata_q;
      OP_INC:  new_dat = base + DATA_W'(1);
      default: new_dat = base;
    endcase
    unique case (op_q)
      OP_LD:   own_nx = hit ? own_st : ST_S;
      OP_LDX:  own_nx = (hit && (own_st == ST_E || own_st == ST_M)) ? own_st
                        : (peer_mod ? ST_M : ST_E);
      default: own_nx = ST_M;
    endcase
  end

  always_comb begin
    for (int p = 0; p < N_CPU; p++) begin
      st_d[p]  = st[p];
      tag_d[p] = tag[p];
      dat_d[p] = dat[p];
      if (cur_q == IDX_W'(p)) begin
        st_d[p]  = own_nx;
        tag_d[p] = addr_q;
        dat_d[p] = new_dat;
      end else if (peer_hit[p]) begin
        if (op_q != OP_LD)  st_d[p] = ST_I;
        else if (!hit)      st_d[p] = ST_S;
      end
    end
  end

  logic flush;
  assign flush = (op_q == OP_LD) && !hit && peer_mod;

  mesi_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni,
    .rd_addr_i(addr_q), .rd_data_o(mem_rd),
    .vic_en_i(exec && vic_dirty), .vic_addr_i(own_tag), .vic_data_i(own_dat),
    .req_addr_i(addr_q),
    .req_data_we_i(exec && flush), .req_data_i(peer_dat),
    .req_flag_we_i(exec && (flush || is_write)), .req_flag_i(flush),
    .valid_o(mem_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= '0;
      rdata_o <= '0;
    end else begin
      done_o <= '0;
      if (exec) begin
        done_o[cur_q] <= 1'b1;
        rdata_o       <= new_dat;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_done_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_o) |=> (done_o == '0));
  assert_done_after_exec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_o) |-> $past(phase_q == PH_EXEC));
  assert_grant_lowest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_any |-> ($onehot(arb_gnt) && ((arb_gnt & ~req_valid_i) == '0)
                 && (((arb_gnt - 1'b1) & req_valid_i) == '0)));

  for (genvar a = 0; a < N_CPU; a++) begin : g_chk
    assert_dirty_stale_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st[a] == ST_M) |-> !mem_valid_o[tag[a]]);
    assert_clean_fresh_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st[a] == ST_S || st[a] == ST_E) |-> mem_valid_o[tag[a]]);
    for (genvar b = a + 1; b < N_CPU; b++) begin : g_pair
      assert_single_owner_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st[a] != ST_I && st[b] != ST_I && tag[a] == tag[b])
          |-> (st[a] == ST_S && st[b] == ST_S));
    end
  end
endmodule

// File: tb/mesi_snoop_ctrl_tb_top.sv
module mesi_snoop_ctrl_tb_top;
  localparam int N = 4, AW = 4, DW = 8, DEPTH = 1 << AW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      req_valid = '0;
  logic [2*N-1:0]    req_op = '0;
  logic [N*AW-1:0]   req_addr = '0;
  logic [N*DW-1:0]   req_wdata = '0;
  logic [N-1:0]      done;
  logic [DW-1:0]     rdata;
  logic [2*N-1:0]    line_state;
  logic [N*AW-1:0]   line_tag;
  logic [DEPTH-1:0]  mem_valid;

  int checks = 0, errors = 0;

  logic [1:0]    m_st  [N];
  logic [AW-1:0] m_tag [N];
  logic [DW-1:0] m_dat [N];
  logic [DW-1:0] m_mem [DEPTH];
  logic [DEPTH-1:0] m_mv;

  always #4 clk = ~clk;

  mesi_snoop_ctrl #(.N_CPU(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .done_o(done), .rdata_o(rdata),
    .line_state_o(line_state), .line_tag_o(line_tag), .mem_valid_o(mem_valid)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] exp_states();
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) v[i*2 +: 2] = m_st[i];
    return v;
  endfunction

  // bench reference of one transaction, built from the requirements
  task automatic model_op(input int c, input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, output logic [DW-1:0] rd);
    bit hit;
    int pm;
    logic [DW-1:0] base, nd;
    logic [1:0] ns;
    hit = (m_st[c] != 0) && (m_tag[c] == a);
    pm = -1;
    for (int p = 0; p < N; p++)
      if (p != c && m_st[p] == 3 && m_tag[p] == a) pm = p;
    if (!hit && m_st[c] == 3) begin
      m_mem[m_tag[c]] = m_dat[c];
      m_mv[m_tag[c]]  = 1'b1;
    end
    base = hit ? m_dat[c] : (pm >= 0 ? m_dat[pm] : m_mem[a]);
    nd = (op == 1) ? wd : (op == 3) ? base + 8'd1 : base;
    case (op)
      2'd0: ns = hit ? m_st[c] : 2'd1;
      2'd2: ns = (hit && m_st[c] >= 2) ? m_st[c] : (pm >= 0 ? 2'd3 : 2'd2);
      default: ns = 2'd3;
    endcase
    for (int p = 0; p < N; p++) begin
      if (p != c && m_st[p] != 0 && m_tag[p] == a) begin
        if (op != 0) m_st[p] = 0;
        else if (!hit) begin
          if (m_st[p] == 3) begin
            m_mem[a] = m_dat[p];
            m_mv[a]  = 1'b1;
          end
          m_st[p] = 1;
        end
      end
    end
    if (op == 1 || op == 3) m_mv[a] = 1'b0;
    m_st[c] = ns; m_tag[c] = a; m_dat[c] = nd;
    rd = nd;
  endtask

  task automatic compare_all(input string tag);
    chk(line_state == exp_states(), tag, "line states", line_state, exp_states());
    for (int i = 0; i < N; i++)
      if (m_st[i] != 0)
        chk(line_tag[i*AW +: AW] == m_tag[i], tag, $sformatf("tag cpu%0d", i),
            line_tag[i*AW +: AW], m_tag[i]);
    chk(mem_valid == m_mv, tag, "mem flags", mem_valid, m_mv);
  endtask

  task automatic run_op(input int c, input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input string tag);
    logic [DW-1:0] exp_rd;
    int wait_n;
    @(negedge clk);
    req_op[c*2 +: 2]     = op;
    req_addr[c*AW +: AW] = a;
    req_wdata[c*DW +: DW] = wd;
    req_valid[c] = 1'b1;
    wait_n = 0;
    do begin
      @(negedge clk);
      wait_n++;
    end while (!done[c] && wait_n < 50);
    req_valid[c] = 1'b0;
    if (!done[c]) begin
      chk(1'b0, tag, "done timeout", 0, 1);
      return;
    end
    model_op(c, op, a, wd, exp_rd);
    chk(rdata == exp_rd, tag, "rdata", rdata, exp_rd);
    compare_all(tag);
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
    for (int k = 0; k < DEPTH; k++) m_mem[k] = 0;
    m_mv = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(line_state == '0, "R1", "reset states", line_state, 0);
    chk(mem_valid == '1, "R1", "reset flags", mem_valid, {DEPTH{1'b1}});
    chk(done == '0, "R1", "reset done", done, 0);

    // directed journey of one line
    run_op(0, 2'd0, 4'd0, 8'h00, "R2");
    run_op(3, 2'd0, 4'd0, 8'h00, "R2");
    run_op(0, 2'd0, 4'd8, 8'h00, "R3");
    run_op(2, 2'd2, 4'd0, 8'h00, "R4");
    run_op(2, 2'd1, 4'd0, 8'h5A, "R5");
    run_op(1, 2'd3, 4'd0, 8'h00, "R6");
    chk(rdata == 8'h5B, "R6", "increment of peer data", rdata, 8'h5B);
    run_op(1, 2'd0, 4'd8, 8'h00, "R7");
    chk(mem_valid[0] == 1'b1, "R7", "writeback flag", mem_valid[0], 1);
    run_op(2, 2'd0, 4'd0, 8'h00, "R7");
    chk(rdata == 8'h5B, "R7", "written-back data", rdata, 8'h5B);
    // store to a Shared line, then a load snooping the dirty copy
    run_op(0, 2'd1, 4'd8, 8'hC3, "R5");
    run_op(3, 2'd0, 4'd8, 8'h00, "R8");
    chk(rdata == 8'hC3, "R8", "peer-forwarded data", rdata, 8'hC3);
    chk(line_state[1:0] == 2'd1, "R8", "flushing peer Shared", line_state[1:0], 1);
    // writes to lines not held
    run_op(2, 2'd1, 4'd5, 8'h77, "R9");
    run_op(2, 2'd3, 4'd6, 8'h00, "R9");
    run_op(3, 2'd0, 4'd5, 8'h00, "R11");
    chk(rdata == 8'h77, "R11", "rdata after writeback", rdata, 8'h77);
    run_op(1, 2'd2, 4'd6, 8'h00, "R4");
    chk(line_state[3:2] == 2'd3, "R4", "Modified peer makes requester M", line_state[3:2], 3);

    // R10: simultaneous requests served lowest index first
    begin
      int order_n, cyc;
      logic [DW-1:0] rd_e;
      @(negedge clk);
      for (int c = 1; c < N; c++) begin
        req_op[c*2 +: 2] = 2'd0;
        req_addr[c*AW +: AW] = AW'(8 + c);
        req_valid[c] = 1'b1;
      end
      order_n = 0; cyc = 0;
      while (order_n < 3 && cyc < 60) begin
        @(negedge clk);
        cyc++;
        if (done != '0) begin
          chk($onehot(done), "R10", "single done", done, 0);
          chk(done[order_n + 1] == 1'b1, "R10", "grant order", done, 1 << (order_n + 1));
          for (int c = 0; c < N; c++)
            if (done[c]) begin
              req_valid[c] = 1'b0;
              model_op(c, 2'd0, AW'(8 + c), 8'h00, rd_e);
              chk(rdata == rd_e, "R10", "rdata", rdata, rd_e);
            end
          order_n++;
          @(negedge clk);
          chk(done == '0, "R10", "done one cycle", done, 0);
        end
      end
      req_valid = '0;
      chk(order_n == 3, "R10", "all served", order_n, 3);
      compare_all("R10");
    end

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int c;
      logic [1:0] op;
      logic [AW-1:0] a;
      string t;
      c  = int'($urandom_range(N - 1, 0));
      op = 2'($urandom_range(3, 0));
      a  = AW'($urandom_range(3, 0));
      t  = (op == 0) ? "R2" : (op == 1) ? "R5" : (op == 2) ? "R4" : "R6";
      run_op(c, op, a, 8'($urandom), t);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule